// File: doc/BRIEF.md
# Bus Fault Address Capture Unit

This block sits beside the bus decoders of a processor subsystem and keeps a record of where bus faults happened. It watches three separate ports: instruction fetch, data and system. Each port supplies a one-cycle fault indication and the address of the access that was on that port in the same cycle. When capture is switched on and a port has not yet reported a fault, the first flagged access on that port stores its address and raises a fault-seen status bit for that port.

The stored address then stays frozen, even when more faults arrive on the same port, until software clears the status. Software clears the status by writing anything to the status register. This clears all three bits together. Clearing does not erase the stored addresses. They stay readable until the next capture replaces them. A small word-addressed register interface gives access to the three addresses, the status word and a one-bit capture enable. Reads are combinational from the address port.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset, all five registers (three addresses, status, control) read 0.
- R2: When the enable is 1 and a port's status bit is 0, a fault pulse on that port stores that port's address and sets the port's bit on the same clock edge. The status bits are: bit 0 instruction, bit 1 data, bit 2 system.
- R3: While a port's status bit is 1, later faults on that port change neither its stored address nor its bit.
- R4: A write to offset 0xC clears all three status bits, whatever data is written. Writes to other offsets leave the status unchanged.
- R5: While the enable is 0, no fault stores an address or sets a status bit.
- R6: A fault in the same cycle as a status write is dropped. The port stays clear and its stored address is unchanged.
- R7: Clearing the status leaves every stored address unchanged.
- R8: The read map is: 0x0 instruction address, 0x4 data address, 0x8 system address, 0xC status in bits 2:0, 0x10 enable in bit 0. Every other offset reads 0.
- R9: Turning the enable off keeps existing status bits and stored addresses.
- R10: The three ports capture independently. A fault on one port never changes another port's address or bit.
- R11: A write to 0x10 stores only data bit 0 as the enable, and the new value applies from the next clock edge. The other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| ifetch_fault | input | 1 | Fault pulse from the instruction fetch port |
| ifetch_addr | input | 32 | Instruction fetch address |
| dbus_fault | input | 1 | Fault pulse from the data port |
| dbus_addr | input | 32 | Data access address |
| sbus_fault | input | 1 | Fault pulse from the system port |
| sbus_addr | input | 32 | System access address |

## Verification
On every cycle, the bound properties check the per-port capture rules against the internal capture and clear events. These rules are first-capture loading, freeze while the bit is set, the enable gate, clearing every bit after a status write, and the stored addresses keeping their value across a clear. Only the bench's scenarios can show the following: the read map and the zero value of unmapped offsets, that the data written to the status register does not matter, that writes to other offsets have no effect, the priority of a clear over a fault in the same cycle as seen from the ports, and the one-cycle delay before a new enable value applies.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  localparam int NUM_CH = 3;
  localparam int CH_IFETCH = 0;
  localparam int CH_DBUS   = 1;
  localparam int CH_SBUS   = 2;

  localparam logic [7:0] OFF_STATUS  = 8'h0C;
  localparam logic [7:0] OFF_CONTROL = 8'h10;

  // byte offset of the address register belonging to channel ch
  function automatic logic [7:0] chan_offset(input int ch);
    return 8'(ch * 4);
  endfunction

  // a channel loads when it is armed, enabled, faulting and not being cleared
  function automatic logic capture_hit(input logic fault, input logic enable,
                                       input logic seen, input logic clear);
    return fault && enable && !seen && !clear;
  endfunction

  // next value of a fault-seen bit: clear wins over a new hit
  function automatic logic next_seen(input logic seen, input logic clear,
                                     input logic hit);
    if (clear) return 1'b0;
    return seen || hit;
  endfunction

endpackage

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
  import bfc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          enable,
  output logic          clr_all
);

  logic wr_ctrl;

  assign clr_all = wr && (addr == AW'(OFF_STATUS));
  assign wr_ctrl = wr && (addr == AW'(OFF_CONTROL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
    end else if (wr_ctrl) begin
      enable <= wdata[0];
    end
  end

endmodule

// File: rtl/bfc_channel.sv
module bfc_channel
  import bfc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clr_all,
  input  logic          fault,
  input  logic [DW-1:0] fault_addr,
  output logic          seen,
  output logic [DW-1:0] held_addr,
  output logic          cap_evt
);

  assign cap_evt = capture_hit(fault, enable, seen, clr_all);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
    end else begin
      seen <= next_seen(seen, clr_all, cap_evt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_addr <= '0;
    end else if (cap_evt) begin
      held_addr <= fault_addr;
    end
  end

endmodule

// File: rtl/bfc_rdmux.sv
module bfc_rdmux
  import bfc_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int NCH = NUM_CH
) (
  input  logic [AW-1:0]     addr,
  input  logic [NCH*DW-1:0] held_flat,
  input  logic [NCH-1:0]    seen_vec,
  input  logic              enable,
  output logic [DW-1:0]     rdata
);

  logic [NCH-1:0]    ch_sel;
  logic [NCH*DW-1:0] ch_term;
  logic [DW-1:0]     ch_or;

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ch_sel[i] = (addr == AW'(chan_offset(i)));
    assign ch_term[i*DW +: DW] = ch_sel[i] ? held_flat[i*DW +: DW] : '0;
  end

  always_comb begin
    ch_or = '0;
    for (int i = 0; i < NCH; i++) begin
      ch_or = ch_or | ch_term[i*DW +: DW];
    end
  end

  always_comb begin
    rdata = ch_or;
    if (addr == AW'(OFF_STATUS)) begin
      rdata = DW'(seen_vec);
    end else if (addr == AW'(OFF_CONTROL)) begin
      rdata = DW'(enable);
    end
  end

endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bfc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ifetch_fault,
  input  logic [DW-1:0] ifetch_addr,
  input  logic          dbus_fault,
  input  logic [DW-1:0] dbus_addr,
  input  logic          sbus_fault,
  input  logic [DW-1:0] sbus_addr
);

  localparam int NCH = NUM_CH;

  logic                cap_en;
  logic                clr_all;
  logic [NCH-1:0]      fault_vec;
  logic [NCH*DW-1:0]   fault_addr_flat;
  logic [NCH-1:0]      seen_vec;
  logic [NCH-1:0]      cap_vec;
  logic [NCH*DW-1:0]   held_flat;

  assign fault_vec[CH_IFETCH] = ifetch_fault;
  assign fault_vec[CH_DBUS]   = dbus_fault;
  assign fault_vec[CH_SBUS]   = sbus_fault;
  assign fault_addr_flat[CH_IFETCH*DW +: DW] = ifetch_addr;
  assign fault_addr_flat[CH_DBUS*DW +: DW]   = dbus_addr;
  assign fault_addr_flat[CH_SBUS*DW +: DW]   = sbus_addr;

  bfc_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .enable  (cap_en),
    .clr_all (clr_all)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    bfc_channel #(.DW(DW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cap_en),
      .clr_all    (clr_all),
      .fault      (fault_vec[i]),
      .fault_addr (fault_addr_flat[i*DW +: DW]),
      .seen       (seen_vec[i]),
      .held_addr  (held_flat[i*DW +: DW]),
      .cap_evt    (cap_vec[i])
    );
  end

  bfc_rdmux #(.AW(AW), .DW(DW), .NCH(NCH)) u_rd (
    .addr      (reg_addr),
    .held_flat (held_flat),
    .seen_vec  (seen_vec),
    .enable    (cap_en),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int DW  = 32,
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_en,
  input logic              clr_all,
  input logic [NCH-1:0]    fault_vec,
  input logic [NCH*DW-1:0] fault_addr_flat,
  input logic [NCH-1:0]    seen_vec,
  input logic [NCH*DW-1:0] held_flat
);

  // R4: a status write leaves every bit clear
  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (seen_vec == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R2: first enabled fault loads address and sets bit
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !seen_vec[i] && fault_vec[i] && !clr_all)
      |=> (seen_vec[i] && held_flat[i*DW +: DW] == $past(fault_addr_flat[i*DW +: DW])));

    // R3: a set bit freezes the address until a clear
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_vec[i] && !clr_all) |=> (seen_vec[i] && $stable(held_flat[i*DW +: DW])));

    // R5: nothing is captured while disabled
    a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en && !seen_vec[i]) |=> (!seen_vec[i] && $stable(held_flat[i*DW +: DW])));

    // R6, R7: a clear cycle never alters the stored address
    a_r7_keep_addr: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> $stable(held_flat[i*DW +: DW]));
  end

endmodule

bind bus_fault_capture bfc_checker #(.DW(DW), .NCH(NCH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cap_en          (cap_en),
  .clr_all         (clr_all),
  .fault_vec       (fault_vec),
  .fault_addr_flat (fault_addr_flat),
  .seen_vec        (seen_vec),
  .held_flat       (held_flat)
);

// File: tb/bus_fault_capture_test.sv
`timescale 1ns/100ps
module bus_fault_capture_test;

  typedef struct packed {
    logic        wr;
    logic [7:0]  off;
    logic [31:0] wd;
    logic [2:0]  flt;
    logic [2:0]  est;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0,        3'b111, 3'b000}, // R5 disabled
    '{1'b1, 8'h10, 32'h1,        3'b111, 3'b000}, // R11 enable not yet active
    '{1'b0, 8'h00, 32'h0,        3'b001, 3'b001}, // R2 ifetch
    '{1'b0, 8'h00, 32'h0,        3'b001, 3'b001}, // R3 hold
    '{1'b0, 8'h00, 32'h0,        3'b110, 3'b111}, // R10 others
    '{1'b1, 8'h00, 32'hFFFFFFFF, 3'b000, 3'b111}, // R4 other offset no clear
    '{1'b1, 8'h0C, 32'h0,        3'b000, 3'b000}, // R4 clear, R7 keep
    '{1'b1, 8'h0C, 32'h0,        3'b010, 3'b000}, // R6 clear wins
    '{1'b0, 8'h00, 32'h0,        3'b010, 3'b010}, // R2 data
    '{1'b1, 8'h10, 32'h0,        3'b000, 3'b010}, // R9 disable keeps
    '{1'b0, 8'h00, 32'h0,        3'b101, 3'b010}, // R5 disabled
    '{1'b1, 8'h0C, 32'hFFFFFFFF, 3'b000, 3'b000}, // R4 any data
    '{1'b1, 8'h10, 32'hFFFFFFFE, 3'b100, 3'b000}, // R11 bit0 only
    '{1'b1, 8'h10, 32'h1,        3'b000, 3'b000},
    '{1'b0, 8'h00, 32'h0,        3'b100, 3'b100}, // R2 system
    '{1'b0, 8'h00, 32'h0,        3'b111, 3'b111}  // R10 mix
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [2:0]  flt = 3'b000;
  logic [31:0] fa [3];

  int checks = 0;
  int fails = 0;
  logic        m_en;
  logic [2:0]  m_st;
  logic [31:0] m_addr [3];

  always #2 clk = ~clk;

  bus_fault_capture uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ifetch_fault (flt[0]),
    .ifetch_addr  (fa[0]),
    .dbus_fault   (flt[1]),
    .dbus_addr    (fa[1]),
    .sbus_fault   (flt[2]),
    .sbus_addr    (fa[2])
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [7:0] off, input logic [31:0] exp, input string req);
    reg_addr = off;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic model_reset();
    m_en = 1'b0;
    m_st = 3'b000;
    for (int c = 0; c < 3; c++) m_addr[c] = 32'h0;
  endtask

  // one clock step; the model is written from the requirements
  task automatic step(input vec_t v, input int idx);
    logic clr;
    @(negedge clk);
    reg_wr = v.wr;
    reg_addr = v.off;
    reg_wdata = v.wd;
    flt = v.flt;
    for (int c = 0; c < 3; c++) fa[c] = 32'h1000_0000 + idx * 32'h111 + (c << 24);
    clr = v.wr && (v.off == 8'h0C);
    for (int c = 0; c < 3; c++) begin
      if (clr) m_st[c] = 1'b0;
      else if (m_en && !m_st[c] && v.flt[c]) begin
        m_st[c] = 1'b1;
        m_addr[c] = fa[c];
      end
    end
    if (v.wr && v.off == 8'h10) m_en = v.wd[0];
    @(posedge clk);
    #0.5;
    reg_wr = 1'b0;
    flt = 3'b000;
    read_chk(8'h0C, {29'h0, v.est}, "R2/R4/R5/R6 status table");
    read_chk(8'h0C, {29'h0, m_st}, "R2/R4 status model");
    read_chk(8'h00, m_addr[0], "R3/R7 ifetch address");
    read_chk(8'h04, m_addr[1], "R3/R7 data address");
    read_chk(8'h08, m_addr[2], "R10 system address");
  endtask

  initial begin
    for (int c = 0; c < 3; c++) fa[c] = 32'h0;
    model_reset();
    repeat (3) @(posedge clk);
    #0.5;
    read_chk(8'h00, 32'h0, "R1 ifetch addr reset");
    read_chk(8'h04, 32'h0, "R1 data addr reset");
    read_chk(8'h08, 32'h0, "R1 sys addr reset");
    read_chk(8'h0C, 32'h0, "R1 status reset");
    read_chk(8'h10, 32'h0, "R1 control reset");
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) step(VEC[k], k);

    // R8 and R11: map, control width, unmapped offsets
    read_chk(8'h10, 32'h1, "R11 control reads bit0");
    read_chk(8'h14, 32'h0, "R8 unmapped 0x14");
    read_chk(8'h02, 32'h0, "R8 unmapped 0x02");
    read_chk(8'hFC, 32'h0, "R8 unmapped 0xFC");
    read_chk(8'h0C, 32'h7, "R8 status bits");

    // R1: reset in mid-run returns everything to zero
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #0.5;
    rst_n = 1'b1;
    model_reset();
    read_chk(8'h00, 32'h0, "R1 ifetch addr after reset");
    read_chk(8'h08, 32'h0, "R1 sys addr after reset");
    read_chk(8'h0C, 32'h0, "R1 status after reset");
    read_chk(8'h10, 32'h0, "R1 control after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule